// File: doc/BRIEF.md
# I2C Display Command/Data Writer

This block is a write-only I2C master for a small graphic display controller. Each request presents one payload byte, a flag that marks the byte as a command or as display data, and an address-select strap. For every accepted request the block runs one complete bus transaction: a START, the target address with the write direction bit, a control byte that tells the controller how to treat the payload, the payload itself, and a STOP. The bits are clocked out most significant first.

SCL is generated from the system clock. Each SCL period is split into four equal quarter phases, and the quarter length is a parameter. The default of 17 cycles gives about 397 kHz from a 27 MHz clock. SDA is open-drain: the block only pulls it low or lets it go. After every byte, SDA is released for a ninth clock and the acknowledge level is sampled. A missing acknowledge cuts the frame short with a STOP and raises an error pulse. A clean frame ends with a done pulse. The sequencer that decides which commands to send sits upstream and talks to this block through a valid/ready port.

Top module: `oled_i2c_writer`

## Requirements
- R1: The first byte of every frame is the 7-bit target address followed by a write bit of 0. The address is 0111100 when `addr_sel` is 0 and 0111101 when it is 1, so the byte is 0x78 or 0x7A. The strap is captured when the request is accepted.
- R2: The second byte is a control byte: 0x00 when `req_is_data` is 0 (command) and 0x40 when it is 1 (display data).
- R3: The third byte is `req_byte`. All bytes go out most significant bit first, with one bit per SCL period.
- R4: Every frame opens with exactly one START (SDA falls while SCL is high) and closes with exactly one STOP (SDA rises while SCL is high). The STOP happens before `done` or `nack` is raised.
- R5: Inside a frame, SDA changes only while SCL is low. START and STOP are the only exceptions.
- R6: On the ninth clock of each byte, SDA is released and sampled while SCL is high. If it reads high, the rest of the frame is dropped, a STOP is sent, and `nack` pulses for one cycle.
- R7: After the STOP of a fully acknowledged frame, `done` pulses for exactly one cycle. `done` and `nack` are never high in the same cycle.
- R8: `req_ready` is high only while the block is idle. Requests and request data presented while it is busy are ignored and do not change the frame in flight.
- R9: The SCL period is 4 × `QTR_CYCLES` system clock cycles.
- R10: During and after reset, SCL is high, SDA is released, `req_ready` is 1, and `done` and `nack` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle; request taken when both are high |
| req_is_data | input | 1 | 0 = command payload, 1 = display data payload |
| req_byte | input | 8 | Payload byte |
| addr_sel | input | 1 | Low bit of the 7-bit target address |
| scl_out | output | 1 | I2C clock level |
| sda_pull_low | output | 1 | 1 = pull SDA low, 0 = release |
| sda_in | input | 1 | Sensed SDA bus level |
| done | output | 1 | One-cycle pulse: frame completed with all bytes acknowledged |
| nack | output | 1 | One-cycle pulse: frame aborted on a missing acknowledge |

## Verification
The properties assume three things: the bus target never stretches SCL, the target changes its acknowledge level only while SCL is low, and `QTR_CYCLES` is at least 3, so that the two-stage input synchronizer still sees the acknowledge while SCL is high. The bench target model changes its SDA pull only on a falling SCL edge, and it holds its acknowledge from the eighth falling edge to the ninth. The bench runs with a quarter phase of 5 cycles. Requests are presented only at idle, except in one deliberate case that holds `req_valid` high with altered data during a busy frame.

// File: rtl/oiw_pkg.sv
package oiw_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_START = 2'd1,
    ST_BITS  = 2'd2,
    ST_STOP  = 2'd3
  } oiw_state_e;

  localparam int unsigned FRAME_BYTES = 3;
  localparam int unsigned BYTE_BITS   = 8;
  localparam int unsigned ACK_SLOT    = BYTE_BITS;   // ninth clock of a byte
  localparam int unsigned BIDX_W      = $clog2(BYTE_BITS + 1);
  localparam int unsigned FIDX_W      = $clog2(FRAME_BYTES);

  localparam logic [7:0] CTRL_CMD  = 8'h00;
  localparam logic [7:0] CTRL_DATA = 8'h40;

  typedef struct packed {
    logic [7:0] addr;
    logic [7:0] ctrl;
    logic [7:0] pay;
  } oiw_frame_t;

endpackage

// File: rtl/oiw_sync.sv
module oiw_sync #(
  parameter int unsigned STAGES = 2,
  parameter logic        RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[0] <= RESET_VAL;
          else     chain[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= RESET_VAL;
          else     chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/oiw_quarter_timer.sv
module oiw_quarter_timer #(
  parameter int unsigned QTR_CYCLES = 17
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tick
);
  localparam int unsigned CW = (QTR_CYCLES > 1) ? $clog2(QTR_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(QTR_CYCLES - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else if (cnt == LAST) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end

  assign tick = run && (cnt == LAST);
endmodule

// File: rtl/oiw_frame_reg.sv
module oiw_frame_reg
  import oiw_pkg::*;
#(
  parameter logic [6:0] ADDR_BASE = 7'b0111100
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                load,
  input  logic                is_data,
  input  logic                sel,
  input  logic [7:0]          payload,
  input  logic [FIDX_W-1:0]   byte_idx,
  input  logic [BIDX_W-1:0]   bit_idx,
  output logic                bit_val
);
  oiw_frame_t         frame_q;
  logic [7:0]         bytes [FRAME_BYTES];
  logic [7:0]         cur;

  always_ff @(posedge clk) begin
    if (rst) begin
      frame_q <= '0;
    end else if (load) begin
      frame_q.addr <= {ADDR_BASE[6:1], ADDR_BASE[0] | sel, 1'b0};
      frame_q.ctrl <= is_data ? CTRL_DATA : CTRL_CMD;
      frame_q.pay  <= payload;
    end
  end

  assign bytes[0] = frame_q.addr;
  assign bytes[1] = frame_q.ctrl;
  assign bytes[2] = frame_q.pay;

  always_comb begin
    cur = bytes[0];
    for (int i = 0; i < FRAME_BYTES; i++)
      if (byte_idx == FIDX_W'(i)) cur = bytes[i];
  end

  // MSB first; ack slot index reads as don't-care (line driver releases)
  always_comb begin
    bit_val = 1'b1;
    for (int b = 0; b < BYTE_BITS; b++)
      if (bit_idx == BIDX_W'(b)) bit_val = cur[BYTE_BITS-1-b];
  end
endmodule

// File: rtl/oiw_bit_fsm.sv
module oiw_bit_fsm
  import oiw_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               accept,
  input  logic               tick,
  input  logic               sda_smp,
  output oiw_state_e         st,
  output logic [1:0]         ph,
  output logic [FIDX_W-1:0]  byte_idx,
  output logic [BIDX_W-1:0]  bit_idx,
  output logic               done_p,
  output logic               nack_p
);
  localparam logic [FIDX_W-1:0] LAST_BYTE = FIDX_W'(FRAME_BYTES - 1);
  localparam logic [BIDX_W-1:0] ACK_IDX   = BIDX_W'(ACK_SLOT);

  logic failed;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      ph       <= 2'd0;
      byte_idx <= '0;
      bit_idx  <= '0;
      failed   <= 1'b0;
      done_p   <= 1'b0;
      nack_p   <= 1'b0;
    end else begin
      done_p <= 1'b0;
      nack_p <= 1'b0;
      if (st == ST_IDLE) begin
        if (accept) begin
          st       <= ST_START;
          ph       <= 2'd0;
          byte_idx <= '0;
          bit_idx  <= '0;
          failed   <= 1'b0;
        end
      end else if (tick) begin
        ph <= ph + 2'd1;
        unique case (st)
          ST_START: if (ph == 2'd3) st <= ST_BITS;
          ST_BITS: begin
            if (ph == 2'd3) begin
              if (bit_idx == ACK_IDX) begin
                bit_idx <= '0;
                if (sda_smp) begin
                  failed <= 1'b1;
                  st     <= ST_STOP;
                end else if (byte_idx == LAST_BYTE) begin
                  st <= ST_STOP;
                end else begin
                  byte_idx <= byte_idx + 1'b1;
                end
              end else begin
                bit_idx <= bit_idx + 1'b1;
              end
            end
          end
          ST_STOP: begin
            if (ph == 2'd3) begin
              st     <= ST_IDLE;
              done_p <= !failed;
              nack_p <= failed;
            end
          end
          default: st <= ST_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/oiw_line_drive.sv
module oiw_line_drive
  import oiw_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  oiw_state_e         st,
  input  logic [1:0]         ph,
  input  logic [BIDX_W-1:0]  bit_idx,
  input  logic               bit_val,
  output logic               scl_q,
  output logic               sdl_q
);
  localparam logic [BIDX_W-1:0] ACK_IDX = BIDX_W'(ACK_SLOT);

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sdl_q <= 1'b0;
    end else begin
      unique case (st)
        ST_IDLE: begin
          scl_q <= 1'b1;
          sdl_q <= 1'b0;
        end
        ST_START: begin
          scl_q <= 1'b1;
          sdl_q <= ph[1];
        end
        ST_BITS: begin
          scl_q <= ph[1];
          if (ph == 2'd1) sdl_q <= (bit_idx == ACK_IDX) ? 1'b0 : !bit_val;
        end
        ST_STOP: begin
          scl_q <= ph[1];
          if (ph != 2'd0) sdl_q <= (ph != 2'd3);
        end
        default: begin
          scl_q <= 1'b1;
          sdl_q <= 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/oled_i2c_writer.sv
module oled_i2c_writer
  import oiw_pkg::*;
#(
  parameter int unsigned QTR_CYCLES  = 17,
  parameter int unsigned SYNC_STAGES = 2,
  parameter logic [6:0]  ADDR_BASE   = 7'b0111100
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       req_valid,
  output logic       req_ready,
  input  logic       req_is_data,
  input  logic [7:0] req_byte,
  input  logic       addr_sel,
  output logic       scl_out,
  output logic       sda_pull_low,
  input  logic       sda_in,
  output logic       done,
  output logic       nack
);
  oiw_state_e         seq_state;
  logic [1:0]         seq_phase;
  logic [FIDX_W-1:0]  byte_idx;
  logic [BIDX_W-1:0]  bit_idx;
  logic               qtick;
  logic               sda_smp;
  logic               cur_bit;
  logic               take;

  assign req_ready = (seq_state == ST_IDLE);
  assign take      = req_valid && req_ready;

  oiw_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
    .clk(clk), .rst(rst), .d(sda_in), .q(sda_smp)
  );

  oiw_quarter_timer #(.QTR_CYCLES(QTR_CYCLES)) u_timer (
    .clk(clk), .rst(rst), .run(seq_state != ST_IDLE), .tick(qtick)
  );

  oiw_frame_reg #(.ADDR_BASE(ADDR_BASE)) u_frame (
    .clk(clk), .rst(rst), .load(take), .is_data(req_is_data), .sel(addr_sel),
    .payload(req_byte), .byte_idx(byte_idx), .bit_idx(bit_idx), .bit_val(cur_bit)
  );

  oiw_bit_fsm u_fsm (
    .clk(clk), .rst(rst), .accept(take), .tick(qtick), .sda_smp(sda_smp),
    .st(seq_state), .ph(seq_phase), .byte_idx(byte_idx), .bit_idx(bit_idx),
    .done_p(done), .nack_p(nack)
  );

  oiw_line_drive u_drive (
    .clk(clk), .rst(rst), .st(seq_state), .ph(seq_phase), .bit_idx(bit_idx),
    .bit_val(cur_bit), .scl_q(scl_out), .sdl_q(sda_pull_low)
  );
endmodule

// File: rtl/oiw_checker.sv
module oiw_checker
  import oiw_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input oiw_state_e st,
  input logic       scl,
  input logic       sdl,
  input logic       ready,
  input logic       valid,
  input logic       done,
  input logic       nack
);
  // R5
  sda_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_BITS && $past(st) == ST_BITS && scl && $past(scl)) |-> $stable(sdl));

  // R7
  done_nack_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(done && nack));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R6
  nack_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    nack |=> !nack);

  // R8
  accept_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (valid && ready) |=> !ready);

  // R10
  idle_bus_chk: assert property (@(posedge clk) disable iff (rst)
    ready |-> (scl && !sdl));

  // R4
  end_bus_free_chk: assert property (@(posedge clk) disable iff (rst)
    (done || nack) |-> (scl && !sdl && $past(scl)));
endmodule

bind oled_i2c_writer oiw_checker i_oiw_checker (
  .clk(clk), .rst(rst), .st(seq_state), .scl(scl_out), .sdl(sda_pull_low),
  .ready(req_ready), .valid(req_valid), .done(done), .nack(nack)
);

// File: tb/test_oled_i2c_writer.sv
`timescale 1ns/1ps
module test_oled_i2c_writer;
  localparam int QTR = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_is_data = 1'b0, addr_sel = 1'b0;
  logic [7:0] req_byte = 8'h00;
  logic req_ready, scl_out, sda_pull_low, done, nack;
  logic slave_low = 1'b0;
  wire  sda_bus = !(sda_pull_low || slave_low);

  always #2.5 clk = ~clk;

  oled_i2c_writer #(.QTR_CYCLES(QTR)) i_oled_i2c_writer (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_is_data(req_is_data), .req_byte(req_byte), .addr_sel(addr_sel),
    .scl_out(scl_out), .sda_pull_low(sda_pull_low), .sda_in(sda_bus),
    .done(done), .nack(nack)
  );

  typedef struct { logic [7:0] a, c, p; int nk; } exp_t;
  exp_t exp_q [$];

  int n_cmp = 0, n_bad = 0;
  int cyc = 0;
  int nack_plan = 3;
  bit finished = 0;

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, expv);
    end
  endtask

  task automatic wrap_up();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual %0d expected <150000 cycles", cyc);
      wrap_up();
    end
  end

  // target model + monitor
  logic p_scl = 1'b1, p_sda = 1'b1;
  bit in_frame = 0;
  int bitcnt = 0, nbytes = 0, starts = 0, last_rise = 0, per = 0;
  logic [7:0] rx [4];
  logic [7:0] sh = 8'h00;

  always @(negedge clk) begin
    if (rst) begin
      p_scl = 1'b1; p_sda = 1'b1; in_frame = 0; slave_low = 1'b0;
    end else begin
      if (scl_out && p_scl && p_sda && !sda_bus) begin
        if (in_frame) starts++;
        else begin in_frame = 1; starts = 1; bitcnt = 0; nbytes = 0; end
      end else if (scl_out && p_scl && !p_sda && sda_bus) begin
        if (!in_frame || exp_q.size() == 0) begin
          check(0, "R8 unexpected frame", 0, 1);
        end else begin
          exp_t e;
          int want;
          e = exp_q.pop_front();
          want = (e.nk < 3) ? e.nk + 1 : 3;
          check(nbytes == want, "R6 byte count", nbytes, want);
          check(starts == 1, "R4/R5 single START in frame", starts, 1);
          if (nbytes >= 1) check(rx[0] == e.a, "R1 address byte", rx[0], e.a);
          if (nbytes >= 2) check(rx[1] == e.c, "R2 control byte", rx[1], e.c);
          if (nbytes >= 3) check(rx[2] == e.p, "R3 payload byte", rx[2], e.p);
        end
        in_frame = 0;
      end else if (!p_scl && scl_out && in_frame) begin
        if (bitcnt >= 1 && bitcnt <= 8) per = cyc - last_rise;
        last_rise = cyc;
        if (bitcnt < 8) begin
          sh = {sh[6:0], sda_bus};
          bitcnt++;
          if (bitcnt == 8) begin
            if (nbytes < 4) rx[nbytes] = sh;
            nbytes++;
          end
        end else begin
          bitcnt = 0;
        end
      end else if (p_scl && !scl_out) begin
        if (in_frame && bitcnt == 8) slave_low = ((nbytes - 1) != nack_plan);
        else slave_low = 1'b0;
      end
      p_scl = scl_out;
      p_sda = sda_bus;
    end
  end

  task automatic send(input logic sel, input logic isd, input logic [7:0] b,
                      input int nk, input bit busy_poke);
    exp_t e;
    int t;
    bit rdy_seen;
    e.a = sel ? 8'h7A : 8'h78;
    e.c = isd ? 8'h40 : 8'h00;
    e.p = b;
    e.nk = nk;
    exp_q.push_back(e);
    nack_plan = nk;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; addr_sel = sel; req_is_data = isd; req_byte = b;
    @(negedge clk);
    if (busy_poke) begin
      req_byte = ~b; req_is_data = !isd; addr_sel = !sel;
      rdy_seen = 0;
      for (int k = 0; k < 100; k++) begin
        @(negedge clk);
        if (req_ready) rdy_seen = 1;
      end
      check(!rdy_seen, "R8 ready low while busy", rdy_seen, 0);
    end
    req_valid = 1'b0;
    t = 0;
    while (!(done || nack) && t < 5000) begin @(negedge clk); t++; end
    check(done == (nk == 3), "R7 done pulse", done, nk == 3);
    check(nack == (nk != 3), "R6 nack pulse", nack, nk != 3);
    check(exp_q.size() == 0, "R4 STOP before outcome", exp_q.size(), 0);
    @(negedge clk);
    check(!done && !nack, "R7 single-cycle outcome", {done, nack}, 0);
  endtask

  initial begin
    repeat (8) @(negedge clk);
    // R10
    check(scl_out == 1'b1, "R10 scl idle high", scl_out, 1);
    check(sda_pull_low == 1'b0, "R10 sda released", sda_pull_low, 0);
    check(req_ready == 1'b1, "R10 ready", req_ready, 1);
    check(!done && !nack, "R10 no pulses", {done, nack}, 0);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    send(1'b0, 1'b0, 8'hAE, 3, 0);
    check(per == 4 * QTR, "R9 SCL period", per, 4 * QTR);
    send(1'b1, 1'b1, 8'hA5, 3, 0);
    send(1'b0, 1'b0, 8'h81, 3, 0);
    send(1'b1, 1'b1, 8'h01, 3, 0);
    send(1'b0, 1'b1, 8'hFF, 3, 0);
    send(1'b0, 1'b0, 8'h3C, 0, 0);
    send(1'b1, 1'b1, 8'h5A, 1, 0);
    send(1'b0, 1'b1, 8'hC3, 2, 0);
    send(1'b0, 1'b1, 8'h96, 3, 1);
    send(1'b1, 1'b0, 8'h00, 3, 0);
    repeat (20) @(negedge clk);
    check(scl_out && !sda_pull_low && req_ready, "R8 no extra frame, bus idle",
          {scl_out, sda_pull_low, req_ready}, 3'b101);
    wrap_up();
  end
endmodule